// File: doc/BRIEF.md
# Indirect Connection Memory Access Port

This block is the host side of a large connection memory. The memory sits outside the block and is shared with a switching engine, so the host never addresses it directly. It works through a small bank of byte-wide staging registers instead. To write, the host loads the two write-data bytes and the low address byte. It then writes the high address byte, and that write starts the transfer. A direction bit in the same byte turns the transfer into a read. A read leaves the fetched word in two read-data registers.

A free-running arbitration counter divides time into frames of `ARB_CYCLE` clocks. The host owns only the first clock of each frame. During every other clock the memory address follows the engine's address input. A launched access is latched into its own holding registers, so the staging registers may be reloaded while it is pending. The host polls a busy bit to learn when the access has finished.

The block also collects two interrupt events: frame evaluation complete and procedure complete. It holds a mask for them and drives an active-low interrupt pin.

Top module: `conn_mem_port`

## Requirements
- R1: After reset, every register reads 0, `int_n` is 1, `host_slot` is high, and `mem_we` and `mem_re` are low.
- R2: Register offsets on `bus_addr` are as follows. 0 is write data bits 7:0. 1 is write data bits 11:8, held in byte bits 3:0. 2 is address bits 7:0. 3 is the launch byte: bits 2:0 carry address bits 10:8 and bit 7 selects a read. 4 is read data bits 7:0. 5 is read data bits 11:8, in byte bits 3:0. 6 is status, with busy in bit 0. 7 is interrupt status. 8 is the mask. Writable registers read back what was written. Unimplemented bits and unused offsets read 0. `bus_rdata` shows the selected register one clock after `bus_rd` is sampled.
- R3: `host_slot` is high for one clock in every `ARB_CYCLE`, starting at the first clock after reset. A launch with bit 7 at 0 while idle produces exactly one `mem_we` pulse. That pulse falls in a host slot and writes the staged data to the staged address, with the address byte making address bits 10:8.
- R4: Busy reads 1 from the clock after a launch. It returns to 0 no more than `ARB_CYCLE`+1 clocks after the launch edge.
- R5: A launch with bit 7 at 1 produces one `mem_re` pulse in a host slot. The word returned on `mem_rdata` one clock later is stored in the read-data registers, and busy then clears.
- R6: A write to offset 3 while busy is ignored: it neither starts an access nor changes the launch byte. Changes to the staging registers while busy do not alter the access in flight.
- R7: The read-data registers change only when a read access completes. Write accesses leave them unchanged.
- R8: A pulse on `ev_frame_done` sets interrupt bit 0, and a pulse on `ev_proc_done` sets bit 1. `int_n` is 0 while any set bit has its mask bit at 0.
- R9: A mask bit of 1 keeps its status bit from pulling `int_n` low. The status bit still reads back as set.
- R10: Reading interrupt status clears exactly the bits it returned. An event arriving in the same clock as the read stays set.
- R11: Outside a host access cycle, `mem_addr` follows `eng_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Register write byte |
| bus_rdata | output | 8 | Register read byte, valid one clock after the read strobe |
| ev_frame_done | input | 1 | Frame evaluation complete event pulse |
| ev_proc_done | input | 1 | Procedure complete event pulse |
| int_n | output | 1 | Interrupt pin, active low |
| eng_addr | input | AW | Switching engine memory address |
| host_slot | output | 1 | Marks the clock reserved for host access |
| mem_addr | output | AW | Shared memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | DW | Memory write word |
| mem_rdata | input | DW | Memory read word, one clock after `mem_re` |

## Verification
A register read returns its byte one clock after the strobe is sampled. The scoreboard therefore pops its expected byte on the falling edge that follows that rising edge. Busy is checked on the clock straight after a launch. The bench then waits `ARB_CYCLE`+1 clocks, a fixed interval equal to the worst case, before it expects idle, and memory writes are compared against a queue on the edge where `mem_we` is sampled. Interrupt events take one register stage, so `int_n` is checked on the falling edge after the event edge.

// File: rtl/conn_mem_port.sv
module conn_mem_port #(
  parameter int AW        = 11,
  parameter int DW        = 12,
  parameter int ARB_CYCLE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [3:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          ev_frame_done,
  input  logic          ev_proc_done,
  output logic          int_n,
  input  logic [AW-1:0] eng_addr,
  output logic          host_slot,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int AHW = AW - 8;
  localparam int DHW = DW - 8;
  localparam int CW  = $clog2(ARB_CYCLE);
  localparam logic [3:0] A_DLO = 4'd0, A_DHI = 4'd1, A_ALO = 4'd2, A_AHI = 4'd3,
                         A_RLO = 4'd4, A_RHI = 4'd5, A_STA = 4'd6, A_IRQ = 4'd7,
                         A_MSK = 4'd8;

  logic [7:0]     dlo, alo, rd_mux;
  logic [DHW-1:0] dhi;
  logic [AHW-1:0] ahi;
  logic           dir_rd;
  logic [DW-1:0]  rdbuf, acc_data;
  logic [AW-1:0]  acc_addr;
  logic           acc_rd, busy, issued;
  logic [CW-1:0]  slot_cnt;
  logic [1:0]     irq, mask;

  wire wsel_dlo = bus_wr && bus_addr == A_DLO;
  wire wsel_dhi = bus_wr && bus_addr == A_DHI;
  wire wsel_alo = bus_wr && bus_addr == A_ALO;
  wire wsel_msk = bus_wr && bus_addr == A_MSK;
  wire launch   = bus_wr && bus_addr == A_AHI && !busy;
  wire irq_rd   = bus_rd && bus_addr == A_IRQ;
  wire issue    = busy && !issued && host_slot;

  assign host_slot = slot_cnt == '0;
  assign mem_we    = issue && !acc_rd;
  assign mem_re    = issue && acc_rd;
  assign mem_addr  = issue ? acc_addr : eng_addr;
  assign mem_wdata = acc_data;
  assign int_n     = ~|(irq & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_cnt <= '0;
    else if (slot_cnt == CW'(ARB_CYCLE - 1)) slot_cnt <= '0;
    else slot_cnt <= slot_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlo  <= '0;
      dhi  <= '0;
      alo  <= '0;
      ahi  <= '0;
      dir_rd <= 1'b0;
      mask <= '0;
    end else begin
      if (wsel_dlo) dlo <= bus_wdata;
      if (wsel_dhi) dhi <= bus_wdata[DHW-1:0];
      if (wsel_alo) alo <= bus_wdata;
      if (wsel_msk) mask <= bus_wdata[1:0];
      if (launch) begin
        ahi    <= bus_wdata[AHW-1:0];
        dir_rd <= bus_wdata[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      issued   <= 1'b0;
      acc_rd   <= 1'b0;
      acc_addr <= '0;
      acc_data <= '0;
      rdbuf    <= '0;
    end else begin
      issued <= issue;
      if (launch) begin
        busy     <= 1'b1;
        acc_rd   <= bus_wdata[7];
        acc_addr <= {bus_wdata[AHW-1:0], alo};
        acc_data <= {dhi, dlo};
      end else if (issued) begin
        busy <= 1'b0;
        if (acc_rd) rdbuf <= mem_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= '0;
    else irq <= (irq & ~(irq_rd ? irq : 2'b00)) | {ev_proc_done, ev_frame_done};
  end

  always_comb begin
    unique case (bus_addr)
      A_DLO:   rd_mux = dlo;
      A_DHI:   rd_mux = {{(8-DHW){1'b0}}, dhi};
      A_ALO:   rd_mux = alo;
      A_AHI:   rd_mux = {dir_rd, {(7-AHW){1'b0}}, ahi};
      A_RLO:   rd_mux = rdbuf[7:0];
      A_RHI:   rd_mux = {{(8-DHW){1'b0}}, rdbuf[DW-1:8]};
      A_STA:   rd_mux = {7'd0, busy};
      A_IRQ:   rd_mux = {6'd0, irq};
      A_MSK:   rd_mux = {6'd0, mask};
      default: rd_mux = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/conn_mem_port_chk.sv
module conn_mem_port_chk #(
  parameter int AW        = 11,
  parameter int ARB_CYCLE = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [3:0]    bus_addr,
  input logic          busy,
  input logic [AW-1:0] acc_addr,
  input logic          host_slot,
  input logic          mem_we,
  input logic          mem_re,
  input logic          ev_frame_done,
  input logic          ev_proc_done,
  input logic [1:0]    mask,
  input logic          int_n
);
  logic [15:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 16'd1;
    else busy_len <= '0;
  end

  p_slot_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> host_slot);
  p_one_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));
  p_launch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd3 && !busy) |=> busy);
  p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= 16'(ARB_CYCLE + 1));
  p_relaunch_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == 4'd3) |=> $stable(acc_addr));
  p_irq_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_done && !mask[0] && !bus_wr) |=> !int_n);
  p_irq_proc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_proc_done && !mask[1] && !bus_wr) |=> !int_n);
endmodule

bind conn_mem_port conn_mem_port_chk #(.AW(AW), .ARB_CYCLE(ARB_CYCLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .busy(busy),
  .acc_addr(acc_addr), .host_slot(host_slot), .mem_we(mem_we), .mem_re(mem_re),
  .ev_frame_done(ev_frame_done), .ev_proc_done(ev_proc_done), .mask(mask),
  .int_n(int_n)
);

// File: tb/tb_conn_mem_port.sv
module tb_conn_mem_port;
  localparam int AW = 11, DW = 12, ARB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic ev_frame_done = 0, ev_proc_done = 0, int_n, host_slot, mem_we, mem_re;
  logic [AW-1:0] eng_addr = 0, mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  conn_mem_port #(.AW(AW), .DW(DW), .ARB_CYCLE(ARB)) dut (.*);

  int checks = 0, failures = 0;
  int exp_rv[$], exp_rr[$], exp_wa[$], exp_wd[$];
  logic [DW-1:0] bmem [0:(1<<AW)-1];
  logic cap_pend = 1'b0;

  task automatic check(bit ok, int req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= bmem[mem_addr];
    if (mem_we) begin
      bmem[mem_addr] <= mem_wdata;
      if (exp_wa.size() == 0) check(0, 3, int'(mem_addr), -1);
      else begin
        int a, d;
        a = exp_wa.pop_front();
        d = exp_wd.pop_front();
        check(mem_addr == AW'(a) && mem_wdata == DW'(d), 3,
              int'({mem_addr, mem_wdata}), int'({AW'(a), DW'(d)}));
      end
    end
    cap_pend <= bus_rd && rst_n;
  end

  always @(negedge clk) begin
    if (cap_pend) begin
      if (exp_rv.size() == 0) check(0, 2, int'(bus_rdata), -1);
      else begin
        int v, r;
        v = exp_rv.pop_front();
        r = exp_rr.pop_front();
        check(bus_rdata == 8'(v), r, int'(bus_rdata), v);
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, int expv, int req);
    exp_rv.push_back(expv); exp_rr.push_back(req);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pulse(bit frame);
    if (frame) ev_frame_done = 1; else ev_proc_done = 1;
    @(negedge clk);
    ev_frame_done = 0; ev_proc_done = 0;
  endtask

  task automatic settle();
    repeat (ARB + 1) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(int_n == 1 && mem_we == 0 && mem_re == 0, 1, int'({int_n, mem_we, mem_re}), 4);
    rd(4'd6, 0, 1); rd(4'd7, 0, 1); rd(4'd4, 0, 1); rd(4'd5, 0, 1); rd(4'd3, 0, 1);
    // R11 engine address passthrough; R3 slot rate
    eng_addr = 11'h5A3;
    @(negedge clk);
    check(mem_addr == 11'h5A3, 11, int'(mem_addr), 'h5A3);
    begin
      int n = 0;
      for (int i = 0; i < 3 * ARB; i++) begin
        if (host_slot) n++;
        @(negedge clk);
      end
      check(n == 3, 3, n, 3);
    end
    // R2 staging readback
    wr(4'd0, 8'h3C); wr(4'd1, 8'hFA); wr(4'd2, 8'h11);
    rd(4'd0, 'h3C, 2); rd(4'd1, 'h0A, 2); rd(4'd2, 'h11, 2); rd(4'd15, 0, 2);
    // R3 R4 write access
    exp_wa.push_back('h211); exp_wd.push_back('hA3C);
    wr(4'd3, 8'h02);
    rd(4'd6, 1, 4);
    settle();
    rd(4'd6, 0, 4); rd(4'd3, 'h02, 2);
    exp_wa.push_back('h7FF); exp_wd.push_back('h755);
    wr(4'd0, 8'h55); wr(4'd1, 8'h07); wr(4'd2, 8'hFF); wr(4'd3, 8'h07);
    settle();
    // R7 write access leaves read data alone
    rd(4'd4, 0, 7); rd(4'd5, 0, 7);
    // R5 read accesses
    wr(4'd2, 8'h11); wr(4'd3, 8'h82);
    rd(4'd6, 1, 4);
    settle();
    rd(4'd4, 'h3C, 5); rd(4'd5, 'h0A, 5); rd(4'd6, 0, 5);
    wr(4'd2, 8'hFF); wr(4'd3, 8'h87);
    settle();
    rd(4'd4, 'h55, 5); rd(4'd5, 'h07, 5); rd(4'd3, 'h87, 2);
    // R6 relaunch and staging change while busy
    exp_wa.push_back('h140); exp_wd.push_back('h201);
    wr(4'd0, 8'h01); wr(4'd1, 8'h02); wr(4'd2, 8'h40);
    wr(4'd3, 8'h01); wr(4'd3, 8'h05); wr(4'd0, 8'hEE);
    settle();
    rd(4'd3, 'h01, 6); rd(4'd0, 'hEE, 6);
    check(exp_wa.size() == 0, 6, exp_wa.size(), 0);
    wr(4'd3, 8'h81);
    settle();
    rd(4'd4, 'h01, 6); rd(4'd5, 'h02, 6);
    // R7 again
    exp_wa.push_back('h141); exp_wd.push_back('h299);
    wr(4'd0, 8'h99); wr(4'd2, 8'h41); wr(4'd3, 8'h01);
    settle();
    rd(4'd4, 'h01, 7); rd(4'd5, 'h02, 7);
    // R8 interrupt raise and read clear
    pulse(1);
    check(int_n == 0, 8, int_n, 0);
    rd(4'd7, 'h01, 8);
    check(int_n == 1, 10, int_n, 1);
    rd(4'd7, 0, 10);
    // R9 mask
    wr(4'd8, 8'h01); rd(4'd8, 'h01, 9);
    pulse(1);
    check(int_n == 1, 9, int_n, 1);
    pulse(0);
    check(int_n == 0, 8, int_n, 0);
    rd(4'd7, 'h03, 9);
    // R10 event coincident with status read
    pulse(1);
    exp_rv.push_back('h01); exp_rr.push_back(10);
    bus_rd = 1; bus_addr = 4'd7; ev_proc_done = 1;
    @(negedge clk);
    bus_rd = 0; ev_proc_done = 0;
    check(int_n == 0, 10, int_n, 0);
    rd(4'd7, 'h02, 10); rd(4'd7, 0, 10);
    check(int_n == 1, 10, int_n, 1);
    check(exp_wa.size() == 0, 3, exp_wa.size(), 0);
    finish_run();
  end
endmodule